// File: doc/BRIEF.md
# Dual-Channel Status Buffer Reader

This block sits on the transmit side of a two-channel serial digital audio link. It supplies the per-frame channel status bit for each of the two channels. It keeps two independent 8-byte status buffers, one per channel. The host can write them at any time through a simple byte write port. The block steps through both buffers in lockstep and emits one status bit per channel per frame.

The block runs on an internal clock of 128 times the sample rate. Each frame is 128 of these cycles: a 64-cycle subframe for channel A, then a 64-cycle subframe for channel B. The last 2-cycle bit cell of each subframe is the parity slot. A 192-frame status block is made of 24 byte groups of 8 frames each. The 8-byte window is walked three times per block.

The next byte pair is fetched during the parity slot of the last frame of each group. At that moment a 2-bit flag output moves to show which part of the window is being fetched. A maskable, active-low interrupt reports flag edges, which lets the host keep clear of the exact byte being read. A host write that hits the byte under fetch is reported as a collision.

Top module: `cs_status_reader`

## Requirements
- R1: While and just after reset: flags = 00, irq_n = 1, collision = 0, rd_stb = 0, and both status bits are 0. The first fetch happens in the frame that follows reset, and block frame 0 starts 128 cycles after reset is released.
- R2: During frame f of a block, cs_a equals bit (f mod 8) of the byte at host address 08h + ((f/8) mod 8). Bits are sent LSB first, one per frame.
- R3: cs_b follows the same rule using host addresses 10h–17h, independently of channel A. Writes to addresses outside 08h–17h change nothing.
- R4: The 8-byte window repeats three times in each 192-frame block. blk_first is high for the whole of frame 0 and low in every other frame.
- R5: rd_stb is high only in the last two cycles (cycles 126 and 127) of the last frame of each 8-frame group. This is the parity cell of the channel B subframe.
- R6: flags holds bits [2:1] of the offset of the byte pair most recently fetched. It changes only at the first cycle of rd_stb.
- R7: When a fetch changes flag bit k and irq_mask[k] is 1, irq_n goes low in the next cycle. A flag change whose mask bit is 0 leaves irq_n high.
- R8: Once low, irq_n stays low until irq_ack is asserted. It returns high in the cycle after the acknowledge, unless a new unmasked flag edge occurs in that same cycle.
- R9: A write to the channel A or channel B byte under fetch while rd_stb is high pulses collision in the next cycle. The fetched byte keeps its pre-write value, and the new value is sent from the next pass of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, 128 x sample rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_addr | input | 5 | Host byte address (08h–0Fh channel A, 10h–17h channel B) |
| wr_data | input | 8 | Host write data |
| irq_mask | input | 2 | Per-flag interrupt enable |
| irq_ack | input | 1 | Clears a pending interrupt |
| cs_a | output | 1 | Channel A status bit for the current frame |
| cs_b | output | 1 | Channel B status bit for the current frame |
| blk_first | output | 1 | High during frame 0 of the status block |
| flags | output | 2 | Upper offset bits of the byte pair under fetch |
| rd_stb | output | 1 | High while the buffer fetch is in progress |
| irq_n | output | 1 | Active-low interrupt |
| collision | output | 1 | One-cycle pulse for a write to the byte under fetch |

## Verification
The bench loads different patterns into the two channels. It checks every frame of a full block, so a design that swapped the address windows or sent MSB first would show wrong bits at once. A design that advanced the offset past 7 would fail at the window reuse points in frames 64 and 128. The interrupt tests use masks that enable only one flag, so a design that ignores the mask would fire on the masked flag-0 edge in frame 16. A design that self-clears would drop the interrupt before the acknowledge. The collision test writes a new value to byte 0Fh in the exact fetch cycle. A design that read after the write would show the new byte one window pass too early, and a design with no collision detect would leave the collision output low.

// File: rtl/cs_buf_pkg.sv
package cs_buf_pkg;
    localparam int FRAME_CYC = 128;
    localparam int CYC_W     = $clog2(FRAME_CYC);
    localparam int FRAMES    = 192;
    localparam int FRM_W     = $clog2(FRAMES);
    localparam int BYTES     = 8;
    localparam int OFF_W     = $clog2(BYTES);
    localparam int GRP_W     = FRM_W - OFF_W;
    localparam int FLAG_W    = 2;
    localparam int ADDR_W    = 5;
    localparam int NCH       = 2;
    localparam logic [CYC_W-1:0] FETCH_CYC = CYC_W'(FRAME_CYC - 2);

    typedef struct packed {
        logic [7:0] b;
        logic [7:0] a;
    } cs_pair_t;

    function automatic logic [OFF_W-1:0] grp_offset(input logic [GRP_W-1:0] grp);
        return grp[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/cs_timebase.sv
module cs_timebase
    import cs_buf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic             fetch,
    output logic             rd_stb,
    output logic             frame_end,
    output logic             blk_first,
    output logic [OFF_W-1:0] bit_idx,
    output logic [OFF_W-1:0] next_off
);
    logic [CYC_W-1:0] cyc;
    logic [FRM_W-1:0] frm;
    logic [GRP_W-1:0] grp_nx;
    logic             last_in_grp;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
            frm <= FRM_W'(FRAMES - 1);
        end else begin
            cyc <= cyc + 1'b1;
            if (frame_end)
                frm <= (frm == FRM_W'(FRAMES - 1)) ? '0 : frm + 1'b1;
        end
    end

    always_comb begin
        last_in_grp = &frm[OFF_W-1:0];
        frame_end   = &cyc;
        fetch       = last_in_grp && (cyc == FETCH_CYC);
        rd_stb      = last_in_grp && (cyc[CYC_W-1:1] == FETCH_CYC[CYC_W-1:1]);
        blk_first   = (frm == '0);
        bit_idx     = frm[OFF_W-1:0];
        grp_nx      = frm[FRM_W-1:OFF_W] + 1'b1;
        next_off    = grp_offset(grp_nx);
    end

    p_stb_two_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_stb) |=> rd_stb ##1 !rd_stb);
    p_blk_after_stb_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(blk_first) |-> $past(rd_stb));
endmodule

// File: rtl/cs_store.sv
module cs_store
    import cs_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output cs_pair_t          rd_pair
);
    logic [NCH-1:0][7:0] rd_bytes;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [7:0] mem [BYTES];
        logic       sel;
        assign sel = wr_en && (wr_addr[ADDR_W-1:OFF_W] == 2'(c + 1));
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < BYTES; i++) mem[i] <= '0;
            end else if (sel) begin
                mem[wr_addr[OFF_W-1:0]] <= wr_data;
            end
        end
        assign rd_bytes[c] = mem[rd_off];
    end

    assign rd_pair.a = rd_bytes[0];
    assign rd_pair.b = rd_bytes[1];
endmodule

// File: rtl/cs_flag_irq.sv
module cs_flag_irq
    import cs_buf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch,
    input  logic [OFF_W-1:0]  next_off,
    input  logic [FLAG_W-1:0] mask,
    input  logic              ack,
    output logic [FLAG_W-1:0] flags,
    output logic              irq_n
);
    logic [FLAG_W-1:0] nf;
    logic              pend;
    logic              hit;

    assign nf    = next_off[OFF_W-1 -: FLAG_W];
    assign hit   = fetch && |((nf ^ flags) & mask);
    assign irq_n = ~pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            pend  <= 1'b0;
        end else begin
            if (fetch) flags <= nf;
            if (hit)      pend <= 1'b1;
            else if (ack) pend <= 1'b0;
        end
    end

    p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !fetch |=> $stable(flags));
    p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_n && !fetch) |=> irq_n);
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !ack) |=> !irq_n);
endmodule

// File: rtl/cs_status_reader.sv
module cs_status_reader
    import cs_buf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  irq_mask,
    input  logic        irq_ack,
    output logic        cs_a,
    output logic        cs_b,
    output logic        blk_first,
    output logic [1:0]  flags,
    output logic        rd_stb,
    output logic        irq_n,
    output logic        collision
);
    logic             fetch, frame_end;
    logic [OFF_W-1:0] bit_idx, next_off;
    cs_pair_t         rd_pair, nxt, cur;
    logic             wr_hit;

    cs_timebase u_tb (
        .clk(clk), .rst(rst), .fetch(fetch), .rd_stb(rd_stb),
        .frame_end(frame_end), .blk_first(blk_first),
        .bit_idx(bit_idx), .next_off(next_off)
    );

    cs_store u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_off(next_off), .rd_pair(rd_pair)
    );

    cs_flag_irq u_irq (
        .clk(clk), .rst(rst), .fetch(fetch), .next_off(next_off),
        .mask(irq_mask), .ack(irq_ack), .flags(flags), .irq_n(irq_n)
    );

    assign wr_hit = wr_en && rd_stb &&
                    ((wr_addr == {2'b01, next_off}) || (wr_addr == {2'b10, next_off}));

    always_ff @(posedge clk) begin
        if (rst) begin
            nxt       <= '0;
            cur       <= '0;
            collision <= 1'b0;
        end else begin
            if (fetch) nxt <= rd_pair;
            if (frame_end && (&bit_idx)) cur <= nxt;
            collision <= wr_hit;
        end
    end

    assign cs_a = cur.a[bit_idx];
    assign cs_b = cur.b[bit_idx];

    p_coll_stb_r9: assert property (@(posedge clk) disable iff (rst)
        collision |-> $past(rd_stb));
    p_cs_steady_r2: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(cs_a) && $stable(cs_b)));
endmodule

// File: tb/tb_cs_status_reader.sv
module tb_cs_status_reader;
    localparam int CLK_PER = 10;
    localparam logic [7:0] NEW_A7 = 8'h3C;
    // {addr, data}: distinct patterns per channel
    localparam logic [12:0] VEC [16] = '{
        {5'h08, 8'hA5}, {5'h09, 8'h01}, {5'h0A, 8'h80}, {5'h0B, 8'hF0},
        {5'h0C, 8'h0F}, {5'h0D, 8'h5A}, {5'h0E, 8'hC3}, {5'h0F, 8'h96},
        {5'h10, 8'h12}, {5'h11, 8'hFE}, {5'h12, 8'h7F}, {5'h13, 8'h00},
        {5'h14, 8'hFF}, {5'h15, 8'h24}, {5'h16, 8'h99}, {5'h17, 8'h6B}
    };

    logic clk = 0, rst = 1;
    logic wr_en = 0, irq_ack = 0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] irq_mask = '0;
    logic cs_a, cs_b, blk_first, rd_stb, irq_n, collision;
    logic [1:0] flags;

    int n_chk = 0, n_fail = 0, m = 0;
    bit done = 0;
    logic [7:0] sa [8];
    logic [7:0] sb [8];

    always #(CLK_PER/2) clk = ~clk;

    cs_status_reader dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at m=%0d: got %0h expected %0h", req, m, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
        m += n;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        m = 0;
        chk("R1 flags", 32'(flags), 0);
        chk("R1 irq_n", 32'(irq_n), 1);
        chk("R1 collision", 32'(collision), 0);
        chk("R1 rd_stb", 32'(rd_stb), 0);
        chk("R1 cs", 32'({cs_a, cs_b}), 0);
        for (int i = 0; i < 16; i++) begin
            wr_en = 1; wr_addr = VEC[i][12:8]; wr_data = VEC[i][7:0];
            if (i < 8) sa[i] = VEC[i][7:0]; else sb[i-8] = VEC[i][7:0];
            adv(1);
        end
        // out-of-window write, must not disturb anything (R3)
        wr_addr = 5'h18; wr_data = 8'hEE; adv(1);
        wr_addr = 5'h00; adv(1);
        wr_en = 0;
        irq_mask = 2'b10;
        for (int f = 0; f < 192; f++) begin
            int o, b;
            adv(128*(f+1) + 64 - m);
            o = (f/8) % 8; b = f % 8;
            if (f == 64) sa[7] = NEW_A7;
            chk("R2 cs_a", 32'(cs_a), 32'(sa[o][b]));
            chk("R3 cs_b", 32'(cs_b), 32'(sb[o][b]));
            chk("R6 flags", 32'(flags), 32'(o[2:1]));
            chk("R4 blk_first", 32'(blk_first), 32'(f == 0));
            chk("R5 rd_stb mid", 32'(rd_stb), 0);
            if (f == 16) chk("R7 masked edge", 32'(irq_n), 1);
            if (f == 32) chk("R7 unmasked edge", 32'(irq_n), 0);
            if (f == 33) begin
                chk("R8 hold", 32'(irq_n), 0);
                irq_ack = 1; adv(1); irq_ack = 0;
            end
            if (f == 34) begin
                chk("R8 cleared", 32'(irq_n), 1);
                irq_mask = 2'b01;
            end
            if (f == 40) chk("R7 no edge", 32'(irq_n), 1);
            if (f == 48) begin
                chk("R7 flag0 edge", 32'(irq_n), 0);
                irq_ack = 1; adv(1); irq_ack = 0;
            end
            if (f == 49) begin
                chk("R8 cleared 2", 32'(irq_n), 1);
                irq_mask = 2'b00;
            end
            if (f == 64) chk("R7 all masked", 32'(irq_n), 1);
            if (f == 55) begin
                adv(128*56 + 126 - m);
                chk("R5 rd_stb first", 32'(rd_stb), 1);
                chk("R9 no collision yet", 32'(collision), 0);
                wr_en = 1; wr_addr = 5'h0F; wr_data = NEW_A7;
                adv(1);
                wr_en = 0;
                chk("R9 collision", 32'(collision), 1);
                chk("R5 rd_stb second", 32'(rd_stb), 1);
                adv(1);
                chk("R9 collision pulse", 32'(collision), 0);
                chk("R5 rd_stb end", 32'(rd_stb), 0);
            end
            if (f == 10) begin
                wr_en = 1; wr_addr = 5'h0B; wr_data = 8'h11; adv(1); wr_en = 0;
                chk("R9 no collision off-stb", 32'(collision), 0);
                sa[3] = 8'h11;
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired at m=%0d", m);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule